// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block translates 32-bit virtual addresses into 32-bit physical addresses through a fully associative table of entries. Each entry maps two neighbouring pages of equal size. The page size is chosen per entry and runs from 4KB to 16MB in steps of four. A lookup port takes an address, a read/write flag and the current address-space tag. One cycle later it returns the physical address, the cache attribute and a hit flag. When the translation fails, it instead returns a one-hot fault code and keeps the offending address.

Software keeps the table up to date through a small register port. The port holds staging registers for the tag half of an entry, for the even and odd page descriptors, for the size mask, and for the index, wired count and replacement pointer. Four commands move data between the staging registers and the table: indexed read, indexed write, write at the replacement pointer, and probe. The replacement pointer steps down on every clock, never going below the wired count, so the low entries stay safe from replacement.

Top module: `xlat_pair_tlb`

## Requirements
- R1: After reset, lk_done, lk_hit, lk_fault and bad_vaddr read zero. Index reads 0, Wired reads 0 and Random reads N_ENT-1.
- R2: Register select codes are 0 tag (VPN2 in bits 31:13, ASID in bits 7:0), 1 even page and 2 odd page (PFN in 25:6, attribute in 5:3, dirty 2, valid 1, global 0), 3 size mask (bits 24:13), 4 Index (probe-fail in bit 31, entry number in low bits), 5 Random (read-only) and 6 Wired. A write with mg_we reads back on mg_rdata from the next cycle.
- R3: An entry matches a lookup when the VPN2 bits outside its mask agree and either the entry is global or its ASID equals lk_asid. A global entry ignores the ASID.
- R4: With a mask of 2k ones, the page is 2^(12+2k) bytes. Virtual bit 12+2k picks the odd page. The physical address takes the bits below 12+2k from the virtual address and the bits above from the chosen PFN.
- R5: lk_done is high exactly one cycle after lk_valid. lk_fault is one-hot: bit 0 means no entry matched, bit 1 means the chosen page is not valid, and bit 2 means a write to a valid page whose dirty bit is clear. lk_hit is high only when there is no fault.
- R6: bad_vaddr loads the lookup address whenever a fault is reported and holds its value otherwise.
- R7: Command 1 writes the staging registers into the entry named by Index. Command 0 loads that entry back into the staging registers. The entry is global only if both staged global bits are set.
- R8: Command 3 compares the staged tag with every entry. On a match, Index gets that entry number. On no match, Index reads 0x80000000.
- R9: Random steps down by one every clock. After reaching Wired it wraps to N_ENT-1. Writing Wired reloads Random to N_ENT-1.
- R10: Command 2 writes the staging registers into the entry that Random names in that cycle. That entry is never below Wired, and entries below Wired keep their translations.
- R11: lk_cattr returns the attribute field of the page that was chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a store |
| lk_asid | input | 8 | Current address-space tag |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Translation succeeded |
| lk_fault | output | 3 | One-hot fault: miss, invalid, modified |
| lk_paddr | output | 32 | Physical address |
| lk_cattr | output | 3 | Cache attribute of the chosen page |
| bad_vaddr | output | 32 | Address of the most recent faulting lookup |
| mg_cmd_valid | input | 1 | Start a table command |
| mg_cmd | input | 2 | 0 read, 1 indexed write, 2 random write, 3 probe |
| mg_we | input | 1 | Staging register write; dropped while mg_cmd_valid is high |
| mg_sel | input | 3 | Staging register select |
| mg_wdata | input | 32 | Staging register write data |
| mg_rdata | output | 32 | Selected staging register |

## Verification
A corrupted table slot shows up on the next lookup that lands in it, one cycle after the request. It appears as a wrong physical address, a wrong attribute or a fault of the wrong kind. It also shows up at once in an indexed read or a probe. Every slot is covered by lookups to both halves with reads and writes, and every page size is exercised across the sweep. A Random pointer that drifts out of step is visible on its register in the cycle it happens. The full-cycle sequences are checked for two wired counts, and for a wired count at the top index. Random writes are confirmed by a probe and a translation, and they must leave the wired entries intact.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VAW     = 32;
  localparam int PGSH    = 12;
  localparam int VPN2LSB = 13;
  localparam int VPN2W   = VAW - VPN2LSB;
  localparam int MASKW   = 12;
  localparam int SPANW   = MASKW + 1;
  localparam int ASIDW   = 8;
  localparam int PFNW    = VAW - PGSH;
  localparam int ATTRW   = 3;
  localparam int NFLT    = 3;
  localparam int FLT_MISS = 0;
  localparam int FLT_INV  = 1;
  localparam int FLT_MOD  = 2;

  typedef struct packed {
    logic [PFNW-1:0]  pfn;
    logic [ATTRW-1:0] attr;
    logic             d;
    logic             v;
  } page_t;

  typedef struct packed {
    logic [VPN2W-1:0] vpn2;
    logic [MASKW-1:0] mask;
    logic [ASIDW-1:0] asid;
    logic             g;
    page_t [1:0]      pg;
  } ent_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WIDX  = 2'd1,
    OP_WRND  = 2'd2,
    OP_PROBE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RS_HI     = 3'd0,
    RS_LO0    = 3'd1,
    RS_LO1    = 3'd2,
    RS_MASK   = 3'd3,
    RS_INDEX  = 3'd4,
    RS_RANDOM = 3'd5,
    RS_WIRED  = 3'd6
  } rsel_e;
endpackage

// File: rtl/xlat_ent_cmp.sv
module xlat_ent_cmp
  import xlat_pkg::*;
(
  input  logic [VPN2W-1:0] ent_vpn2,
  input  logic [MASKW-1:0] ent_mask,
  input  logic [ASIDW-1:0] ent_asid,
  input  logic             ent_g,
  input  logic [VPN2W-1:0] key_vpn2,
  input  logic [ASIDW-1:0] key_asid,
  output logic             match
);
  logic [VPN2W-1:0] care;

  // R3: masked VPN2 compare, ASID compare skipped for global entries
  always_comb begin
    care  = ~{{(VPN2W-MASKW){1'b0}}, ent_mask};
    match = (((ent_vpn2 ^ key_vpn2) & care) == '0) &&
            (ent_g || (ent_asid == key_asid));
  end
endmodule

// File: rtl/xlat_first_hit.sv
module xlat_first_hit #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest-numbered match wins
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wired_we,
  input  logic [IW-1:0] wired_q,
  output logic [IW-1:0] rnd_q
);
  localparam logic [IW-1:0] TOP = IW'(N-1);
  logic [IW-1:0] rnd_d;

  // R9: step down to the wired floor, then wrap to the top slot
  always_comb begin
    if (wired_we)                             rnd_d = TOP;
    else if (rnd_q <= wired_q || rnd_q == '0) rnd_d = TOP;
    else                                      rnd_d = rnd_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd_q <= TOP;
    else        rnd_q <= rnd_d;
  end
endmodule

// File: rtl/xlat_pair_tlb.sv
module xlat_pair_tlb
  import xlat_pkg::*;
#(
  parameter int N_ENT = 32,
  localparam int IW = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VAW-1:0]   lk_vaddr,
  input  logic             lk_write,
  input  logic [ASIDW-1:0] lk_asid,
  output logic             lk_done,
  output logic             lk_hit,
  output logic [NFLT-1:0]  lk_fault,
  output logic [VAW-1:0]   lk_paddr,
  output logic [ATTRW-1:0] lk_cattr,
  output logic [VAW-1:0]   bad_vaddr,
  input  logic             mg_cmd_valid,
  input  logic [1:0]       mg_cmd,
  input  logic             mg_we,
  input  logic [2:0]       mg_sel,
  input  logic [VAW-1:0]   mg_wdata,
  output logic [VAW-1:0]   mg_rdata
);
  localparam int PGB = $bits(page_t);

  // staging registers
  logic [VPN2W-1:0] ehi_vpn2_q, ehi_vpn2_d;
  logic [ASIDW-1:0] ehi_asid_q, ehi_asid_d;
  page_t [1:0]      lo_q, lo_d;
  logic [1:0]       lo_g_q, lo_g_d;
  logic [MASKW-1:0] mask_q, mask_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic             pfail_q, pfail_d;
  logic [IW-1:0]    wired_q, wired_d;
  logic             wired_we;
  logic [IW-1:0]    rnd;

  // table
  ent_t             ents [N_ENT];
  logic             ent_we;
  logic [IW-1:0]    ent_wptr;
  ent_t             ent_wdata;
  ent_t             rd_ent;

  logic [N_ENT-1:0] lk_vec, pr_vec;
  logic             lk_found, pr_found;
  logic [IW-1:0]    lk_idx, pr_idx;

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_slot
    ent_t slot_q, slot_d;

    always_comb slot_d = (ent_we && ent_wptr == IW'(gi)) ? ent_wdata : slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
    end

    assign ents[gi] = slot_q;

    xlat_ent_cmp u_lk_cmp (
      .ent_vpn2 (slot_q.vpn2),
      .ent_mask (slot_q.mask),
      .ent_asid (slot_q.asid),
      .ent_g    (slot_q.g),
      .key_vpn2 (lk_vaddr[VAW-1:VPN2LSB]),
      .key_asid (lk_asid),
      .match    (lk_vec[gi])
    );

    xlat_ent_cmp u_pr_cmp (
      .ent_vpn2 (slot_q.vpn2),
      .ent_mask (slot_q.mask),
      .ent_asid (slot_q.asid),
      .ent_g    (slot_q.g),
      .key_vpn2 (ehi_vpn2_q),
      .key_asid (ehi_asid_q),
      .match    (pr_vec[gi])
    );
  end

  xlat_first_hit #(.N(N_ENT)) u_lk_pick (.vec(lk_vec), .found(lk_found), .idx(lk_idx));
  xlat_first_hit #(.N(N_ENT)) u_pr_pick (.vec(pr_vec), .found(pr_found), .idx(pr_idx));

  xlat_victim #(.N(N_ENT)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .wired_we (wired_we),
    .wired_q  (wired_q),
    .rnd_q    (rnd)
  );

  // ---------------- lookup path ----------------
  ent_t             lk_ent;
  page_t            lk_pg;
  logic [SPANW-1:0] span_sel, span_off;
  logic             lk_odd;
  logic [VAW-1:0]   lk_pa;
  logic [NFLT-1:0]  lk_flt;

  // R4: size mask picks the even/odd select bit and the offset span
  always_comb begin
    lk_ent   = ents[lk_idx];
    span_sel = {lk_ent.mask, 1'b1} & ~{1'b0, lk_ent.mask};
    span_off = {1'b0, lk_ent.mask};
    lk_odd   = |(span_sel & lk_vaddr[PGSH+SPANW-1:PGSH]);
    lk_pg    = lk_ent.pg[lk_odd];
    lk_pa    = {lk_pg.pfn[PFNW-1:SPANW],
                (lk_vaddr[PGSH+SPANW-1:PGSH] & span_off) |
                (lk_pg.pfn[SPANW-1:0] & ~span_off),
                lk_vaddr[PGSH-1:0]};
    // R5: fault priority miss, then invalid, then modified
    lk_flt = '0;
    if (!lk_found)              lk_flt[FLT_MISS] = 1'b1;
    else if (!lk_pg.v)          lk_flt[FLT_INV]  = 1'b1;
    else if (lk_write && !lk_pg.d) lk_flt[FLT_MOD] = 1'b1;
  end

  logic             done_d, hit_d;
  logic [NFLT-1:0]  flt_d;
  logic [VAW-1:0]   pa_d, bad_d;
  logic [ATTRW-1:0] attr_d;

  always_comb begin
    done_d = lk_valid;
    hit_d  = lk_valid && (lk_flt == '0);
    flt_d  = lk_valid ? lk_flt : '0;
    pa_d   = lk_valid ? lk_pa : lk_paddr;
    attr_d = lk_valid ? lk_pg.attr : lk_cattr;
    // R6: capture the faulting address
    bad_d  = (lk_valid && lk_flt != '0) ? lk_vaddr : bad_vaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_done   <= 1'b0;
      lk_hit    <= 1'b0;
      lk_fault  <= '0;
      lk_paddr  <= '0;
      lk_cattr  <= '0;
      bad_vaddr <= '0;
    end else begin
      lk_done   <= done_d;
      lk_hit    <= hit_d;
      lk_fault  <= flt_d;
      lk_paddr  <= pa_d;
      lk_cattr  <= attr_d;
      bad_vaddr <= bad_d;
    end
  end

  // ---------------- management path ----------------
  always_comb begin
    ehi_vpn2_d = ehi_vpn2_q;
    ehi_asid_d = ehi_asid_q;
    lo_d       = lo_q;
    lo_g_d     = lo_g_q;
    mask_d     = mask_q;
    idx_d      = idx_q;
    pfail_d    = pfail_q;
    wired_d    = wired_q;
    wired_we   = 1'b0;
    ent_we     = 1'b0;
    ent_wptr   = idx_q;
    ent_wdata  = '{vpn2: ehi_vpn2_q, mask: mask_q, asid: ehi_asid_q,
                   g: lo_g_q[0] & lo_g_q[1], pg: lo_q};
    rd_ent     = ents[idx_q];
    if (mg_cmd_valid) begin
      unique case (op_e'(mg_cmd))
        OP_READ: begin  // R7
          ehi_vpn2_d = rd_ent.vpn2;
          ehi_asid_d = rd_ent.asid;
          mask_d     = rd_ent.mask;
          lo_d       = rd_ent.pg;
          lo_g_d     = {2{rd_ent.g}};
        end
        OP_WIDX: ent_we = 1'b1;
        OP_WRND: begin  // R10
          ent_we   = 1'b1;
          ent_wptr = rnd;
        end
        OP_PROBE: begin  // R8
          idx_d   = pr_found ? pr_idx : '0;
          pfail_d = !pr_found;
        end
      endcase
    end else if (mg_we) begin
      case (rsel_e'(mg_sel))
        RS_HI: begin
          ehi_vpn2_d = mg_wdata[VAW-1:VPN2LSB];
          ehi_asid_d = mg_wdata[ASIDW-1:0];
        end
        RS_LO0: begin
          lo_d[0]   = mg_wdata[PGB:1];
          lo_g_d[0] = mg_wdata[0];
        end
        RS_LO1: begin
          lo_d[1]   = mg_wdata[PGB:1];
          lo_g_d[1] = mg_wdata[0];
        end
        RS_MASK:  mask_d = mg_wdata[VPN2LSB+MASKW-1:VPN2LSB];
        RS_INDEX: begin
          idx_d   = mg_wdata[IW-1:0];
          pfail_d = 1'b0;
        end
        RS_WIRED: begin
          wired_d  = mg_wdata[IW-1:0];
          wired_we = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ehi_vpn2_q <= '0;
      ehi_asid_q <= '0;
      lo_q       <= '0;
      lo_g_q     <= '0;
      mask_q     <= '0;
      idx_q      <= '0;
      pfail_q    <= 1'b0;
      wired_q    <= '0;
    end else begin
      ehi_vpn2_q <= ehi_vpn2_d;
      ehi_asid_q <= ehi_asid_d;
      lo_q       <= lo_d;
      lo_g_q     <= lo_g_d;
      mask_q     <= mask_d;
      idx_q      <= idx_d;
      pfail_q    <= pfail_d;
      wired_q    <= wired_d;
    end
  end

  // R2: register read mux
  always_comb begin
    case (rsel_e'(mg_sel))
      RS_HI:     mg_rdata = {ehi_vpn2_q, {(VPN2LSB-ASIDW){1'b0}}, ehi_asid_q};
      RS_LO0:    mg_rdata = {{(VAW-1-PGB){1'b0}}, lo_q[0], lo_g_q[0]};
      RS_LO1:    mg_rdata = {{(VAW-1-PGB){1'b0}}, lo_q[1], lo_g_q[1]};
      RS_MASK:   mg_rdata = {{(VAW-VPN2LSB-MASKW){1'b0}}, mask_q, {VPN2LSB{1'b0}}};
      RS_INDEX:  mg_rdata = {pfail_q, {(VAW-1-IW){1'b0}}, idx_q};
      RS_RANDOM: mg_rdata = {{(VAW-IW){1'b0}}, rnd};
      RS_WIRED:  mg_rdata = {{(VAW-IW){1'b0}}, wired_q};
      default:   mg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xlat_pair_tlb_chk.sv
module xlat_pair_tlb_chk
  import xlat_pkg::*;
#(
  parameter int N_ENT = 32,
  parameter int IW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic            lk_done,
  input logic            lk_hit,
  input logic [NFLT-1:0] lk_fault,
  input logic [VAW-1:0]  bad_vaddr,
  input logic            mg_cmd_valid,
  input logic            mg_we,
  input logic [2:0]      mg_sel,
  input logic [IW-1:0]   rnd,
  input logic [IW-1:0]   wired_q
);
  localparam logic [IW-1:0] TOP = IW'(N_ENT-1);
  logic wired_wr;
  assign wired_wr = mg_we && !mg_cmd_valid && (mg_sel == 3'(RS_WIRED));

  p_done_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_done);

  p_fault_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_fault));

  p_hit_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_fault == '0));

  p_bad_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault == '0) |-> $stable(bad_vaddr));

  p_rnd_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rnd >= wired_q);

  p_wired_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wired_wr |=> (rnd == TOP));

  p_rnd_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wired_wr |=> (rnd == TOP || rnd == $past(rnd) - 1'b1));
endmodule

bind xlat_pair_tlb xlat_pair_tlb_chk #(.N_ENT(N_ENT), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_done      (lk_done),
  .lk_hit       (lk_hit),
  .lk_fault     (lk_fault),
  .bad_vaddr    (bad_vaddr),
  .mg_cmd_valid (mg_cmd_valid),
  .mg_we        (mg_we),
  .mg_sel       (mg_sel),
  .rnd          (rnd),
  .wired_q      (wired_q)
);

// File: tb/xlat_pair_tlb_test.sv
`timescale 1ns/1ps
module xlat_pair_tlb_test;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_write;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_asid;
  logic        lk_done, lk_hit;
  logic [2:0]  lk_fault, lk_cattr;
  logic [31:0] lk_paddr, bad_vaddr;
  logic        mg_cmd_valid, mg_we;
  logic [1:0]  mg_cmd;
  logic [2:0]  mg_sel;
  logic [31:0] mg_wdata, mg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] bad_exp = 32'h0;

  always #2.5 clk = ~clk;

  xlat_pair_tlb #(.N_ENT(N)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // model of the programmed table
  function automatic int kk(int i); return i % 7; endfunction
  function automatic logic [11:0] mask_of(int i); return 12'((1 << (2*kk(i))) - 1); endfunction
  function automatic logic [31:0] vbase(int i); return 32'(i) << 25; endfunction
  function automatic logic [7:0] asid_of(int i); return 8'((i*37 + 11) & 255); endfunction
  function automatic logic glob(int i); return (i % 4) == 3; endfunction
  function automatic logic [19:0] pfn_of(int i, int h);
    return 20'(32'h100 + i*32'h351 + h*32'h40000);
  endfunction
  function automatic logic vld(int i, int h); return (h == 0) || (i % 5 != 2); endfunction
  function automatic logic dty(int i, int h); return (h == 1) || (i % 2 == 0); endfunction
  function automatic logic [2:0] attr_of(int i, int h); return 3'(h ? 7 - (i % 8) : i % 8); endfunction
  function automatic logic [31:0] lo_word(int i, int h);
    return {6'b0, pfn_of(i,h), attr_of(i,h), dty(i,h), vld(i,h), glob(i)};
  endfunction
  function automatic logic [31:0] offm(int i); return (32'd1 << (12 + 2*kk(i))) - 1; endfunction
  function automatic logic [31:0] va_of(int i, int h);
    logic [31:0] pat;
    pat = 32'h0005_A5A5 ^ (32'(i) * 32'h1357);
    return vbase(i) | (32'(h) << (12 + 2*kk(i))) | (pat & offm(i));
  endfunction
  function automatic logic [31:0] pa_of(int i, int h, logic [31:0] va);
    return ({pfn_of(i,h), 12'b0} & ~offm(i)) | (va & offm(i));
  endfunction

  // tasks start and end at a falling edge
  task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
    mg_we = 1'b1; mg_sel = sel; mg_wdata = d;
    @(negedge clk);
    mg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] sel, output logic [31:0] d);
    mg_sel = sel;
    #0.1;
    d = mg_rdata;
  endtask

  task automatic cmd(input logic [1:0] op);
    mg_cmd_valid = 1'b1; mg_cmd = op;
    @(negedge clk);
    mg_cmd_valid = 1'b0;
  endtask

  task automatic look(input string tag, input logic [31:0] va, input logic w,
                      input logic [7:0] a, input logic [2:0] ef,
                      input logic [31:0] epa, input logic [2:0] eat);
    lk_valid = 1'b1; lk_vaddr = va; lk_write = w; lk_asid = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({tag, " R5 done"}, 32'(lk_done), 32'd1);
    chk({tag, " R5 fault"}, 32'(lk_fault), 32'(ef));
    chk({tag, " R5 hit"}, 32'(lk_hit), 32'(ef == 3'b0));
    if (ef == 3'b0) begin
      chk({tag, " R4 paddr"}, lk_paddr, epa);
      chk({tag, " R11 attr"}, 32'(lk_cattr), 32'(eat));
    end else begin
      bad_exp = va;
    end
    chk({tag, " R6 badaddr"}, bad_vaddr, bad_exp);
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; lk_valid = 1'b0; lk_write = 1'b0; lk_vaddr = '0; lk_asid = '0;
    mg_cmd_valid = 1'b0; mg_cmd = '0; mg_we = 1'b0; mg_sel = '0; mg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 done", 32'(lk_done), 0);
    chk("R1 hit", 32'(lk_hit), 0);
    chk("R1 fault", 32'(lk_fault), 0);
    chk("R1 bad", bad_vaddr, 0);
    reg_rd(3'd4, d); chk("R1 index", d, 0);
    reg_rd(3'd6, d); chk("R1 wired", d, 0);
    reg_rd(3'd5, d); chk("R1 random", d, N-1);

    // R9 free-running sequence with Wired = 0
    for (int k = 0; k < 34; k++) begin
      reg_rd(3'd5, d); chk("R9 rnd w0", d, 32'(N-1 - (k % N)));
      @(negedge clk);
    end
    reg_wr(3'd6, 32'd20);
    for (int k = 0; k < 30; k++) begin
      reg_rd(3'd5, d); chk("R9 rnd w20", d, 32'(N-1 - (k % (N-20))));
      @(negedge clk);
    end
    reg_wr(3'd6, 32'd31);
    for (int k = 0; k < 4; k++) begin
      reg_rd(3'd5, d); chk("R9 rnd w31", d, 32'(N-1));
      @(negedge clk);
    end
    reg_wr(3'd6, 32'd0);

    // fill table through indexed writes, checking staging readback
    for (int i = 0; i < N; i++) begin
      reg_wr(3'd0, vbase(i) | 32'(asid_of(i)));
      reg_wr(3'd1, lo_word(i, 0));
      reg_wr(3'd2, lo_word(i, 1));
      reg_wr(3'd3, 32'(mask_of(i)) << 13);
      reg_wr(3'd4, 32'(i));
      reg_rd(3'd0, d); chk("R2 hi", d, vbase(i) | 32'(asid_of(i)));
      reg_rd(3'd3, d); chk("R2 mask", d, 32'(mask_of(i)) << 13);
      reg_rd(3'd4, d); chk("R2 index", d, 32'(i));
      cmd(2'd1);
    end

    // R7 indexed read round trip
    for (int i = N-1; i >= 0; i--) begin
      reg_wr(3'd4, 32'(i));
      cmd(2'd0);
      reg_rd(3'd0, d); chk("R7 hi", d, vbase(i) | 32'(asid_of(i)));
      reg_rd(3'd1, d); chk("R7 lo0", d, lo_word(i, 0));
      reg_rd(3'd2, d); chk("R7 lo1", d, lo_word(i, 1));
      reg_rd(3'd3, d); chk("R7 mask", d, 32'(mask_of(i)) << 13);
    end

    // R3 R4 R5 R6 R11 lookup sweep
    for (int i = 0; i < N; i++) begin
      for (int h = 0; h < 2; h++) begin
        for (int w = 0; w < 2; w++) begin
          logic [2:0] ef;
          logic [31:0] va;
          va = va_of(i, h);
          if (!vld(i, h))               ef = 3'b010;
          else if (w == 1 && !dty(i, h)) ef = 3'b100;
          else                           ef = 3'b000;
          look("sweep", va, w[0], asid_of(i), ef, pa_of(i, h, va), attr_of(i, h));
        end
      end
      // R3 foreign ASID: global entries still translate
      look("R3 asid", va_of(i, 0), 1'b0, asid_of(i) ^ 8'h5A,
           glob(i) ? 3'b000 : 3'b001, pa_of(i, 0, va_of(i, 0)), attr_of(i, 0));
    end
    look("R5 miss", 32'hC000_1234, 1'b0, 8'h00, 3'b001, 32'h0, 3'h0);
    @(negedge clk);
    chk("R5 done low", 32'(lk_done), 0);

    // R8 probe: hits ignore bits under the mask
    for (int i = 0; i < N; i++) begin
      reg_wr(3'd0, (va_of(i, 1) & 32'hFFFF_E000) | 32'(asid_of(i)));
      cmd(2'd3);
      reg_rd(3'd4, d); chk("R8 probe hit", d, 32'(i));
      if (!glob(i)) begin
        reg_wr(3'd0, vbase(i) | 32'(asid_of(i) ^ 8'h01));
        cmd(2'd3);
        reg_rd(3'd4, d); chk("R8 probe miss", d, 32'h8000_0000);
      end
    end

    // R10 random writes above a wired floor
    reg_wr(3'd6, 32'd28);
    for (int t = 0; t < 4; t++) begin
      logic [31:0] r;
      logic [31:0] lw;
      repeat (t + 1) @(negedge clk);
      lw = {6'b0, 20'hABC00 + 20'(t), 3'(t), 1'b1, 1'b1, 1'b1};
      reg_wr(3'd0, 32'(40 + t) << 25);
      reg_wr(3'd1, lw);
      reg_wr(3'd2, lw);
      reg_wr(3'd3, 32'h0);
      reg_rd(3'd5, r);
      cmd(2'd2);
      chk("R10 rnd floor", 32'(r >= 28 && r <= 31), 1);
      cmd(2'd3);
      reg_rd(3'd4, d); chk("R10 probe slot", d, r);
      look("R10 xlat", (32'(40 + t) << 25) | 32'h123, 1'b1, 8'h00, 3'b000,
           {20'hABC00 + 20'(t), 12'h123}, 3'(t));
    end
    for (int i = 0; i < 28; i++) begin
      look("R10 kept", va_of(i, 0), 1'b0, asid_of(i), 3'b000,
           pa_of(i, 0, va_of(i, 0)), attr_of(i, 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule